// File: doc/BRIEF.md
# Charge Pump Gain Sequencer

This controller picks the gain of a switched-capacitor LED supply: unity (1x), one and a half (1.5x) or double (2x). It watches per-channel dropout flags. Only channels that are enabled and are not set up as plain open-drain outputs are counted. Once qualified dropout has held without a break for a set number of oscillator ticks, the gain moves up by one step. After the step, the same full hold time must pass again before the next step. Gain only ever moves up by itself. It drops back to unity on a register commit, at the end of a downward brightness ramp, or at the end of a blink period. A forced setting replaces all automatic selection. Shutdown holds the block at unity with its switches idle.

Each upward change restarts a linear strength ramp. The ramp climbs one step per oscillator tick until it reaches full scale, so the pump's inrush current is limited. While the gain is above unity, the block drives two non-overlapping switch phases. The phases swap on every oscillator tick, and both stay low for a short dead time after each swap. The system clock and the oscillator tick are both inputs to the block.

Top module: `pump_gain_ctrl`

## Requirements
- R1: After reset, gain is 0 (1x), strength is 0 and both phases are low. The gain code on the port is 0 = 1x, 1 = 1.5x, 2 = 2x.
- R2: Qualified dropout held for QUAL_TICKS consecutive ticks raises the gain by exactly one step, on the clock edge of the QUAL_TICKS-th tick. The gain never exceeds 2.
- R3: If qualified dropout goes low for even one cycle, the hold count restarts from zero.
- R4: Dropout on a channel with chan_on low, or with chan_gpo high, has no effect on the gain.
- R5: A pulse on commit, grad_down_done or blink_end sets the gain to 0 on the next edge. This takes priority over a step-up due in the same cycle.
- R6: While force_en is high, the gain follows force_sel (0 = 1x, 1 = 1.5x, 2 or 3 = 2x) from the next edge, and dropout has no effect.
- R7: shutdown is high whenever sd_bit is high or every chan_on bit is low. While shutdown is high, the gain is set to 0, strength is set to 0 and both phases are low. This takes priority over everything else.
- R8: strength returns to 0 on every edge at which the gain rises. Otherwise it rises by one per tick and stops at RAMP_STEPS.
- R9: While the gain is above 0 and the block is not in shutdown, ph_a and ph_b are never high together. The active phase swaps on each tick, and both phases stay low for DEAD_CLKS clocks after that tick.
- R10: Any gain change clears the hold count, so the second step needs a full new QUAL_TICKS hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock pulse at the oscillator rate |
| drop_in | input | NCH | Per-channel dropout flags |
| chan_on | input | NCH | Channel has nonzero data |
| chan_gpo | input | NCH | Channel in open-drain output mode |
| commit | input | 1 | Register commit pulse from the serial port |
| grad_down_done | input | 1 | Downward brightness ramp finished |
| blink_end | input | 1 | End of a blink period |
| sd_bit | input | 1 | Shutdown control bit |
| force_en | input | 1 | Forced gain enable |
| force_sel | input | 2 | Forced gain code |
| gain | output | 2 | Current gain code |
| shutdown | output | 1 | Block is in shutdown |
| strength | output | RW | Soft-start strength ramp |
| ph_a | output | 1 | Switch phase A |
| ph_b | output | 1 | Switch phase B |

## Verification
A fallback event can land on the same edge where the hold count completes. In that case the step-up and the return to unity compete. The bench sets this up on purpose: it builds the hold count to one tick short of a step, then pulses commit on the tick that would finish it, and expects the gain to stay at 0. The same collision, and the one between a forced setting and an automatic step, also comes up in the random phase. There, a reference model computes the expected result every cycle from the priority order shutdown > force > fallback > step.

// File: rtl/pump_gain_ctrl.sv
module pump_gain_ctrl #(
  parameter int NCH        = 18,
  parameter int QUAL_TICKS = 340,
  parameter int RAMP_STEPS = 106,
  parameter int DEAD_CLKS  = 2,
  localparam int QW = $clog2(QUAL_TICKS + 1),
  localparam int RW = $clog2(RAMP_STEPS + 1),
  localparam int DW = $clog2(DEAD_CLKS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [NCH-1:0] drop_in,
  input  logic [NCH-1:0] chan_on,
  input  logic [NCH-1:0] chan_gpo,
  input  logic           commit,
  input  logic           grad_down_done,
  input  logic           blink_end,
  input  logic           sd_bit,
  input  logic           force_en,
  input  logic [1:0]     force_sel,
  output logic [1:0]     gain,
  output logic           shutdown,
  output logic [RW-1:0]  strength,
  output logic           ph_a,
  output logic           ph_b
);

  logic [QW-1:0] qcnt;
  logic [DW-1:0] dead;
  logic          phase;
  logic [1:0]    gain_nx;

  wire qual     = |(drop_in & chan_on & ~chan_gpo);
  wire fallback = commit | grad_down_done | blink_end;
  wire [1:0] fsel = (force_sel == 2'd3) ? 2'd2 : force_sel;
  wire step     = tick && qual && (gain != 2'd2) && (qcnt == QW'(QUAL_TICKS - 1));
  wire active   = !shutdown && (gain != 2'd0);

  assign shutdown = sd_bit | ~|chan_on;

  always_comb begin
    if (shutdown)      gain_nx = 2'd0;
    else if (force_en) gain_nx = fsel;
    else if (fallback) gain_nx = 2'd0;
    else if (step)     gain_nx = gain + 2'd1;
    else               gain_nx = gain;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain     <= 2'd0;
      qcnt     <= '0;
      strength <= '0;
    end else begin
      gain <= gain_nx;
      if (shutdown || force_en || fallback || !qual || gain_nx != gain || gain == 2'd2)
        qcnt <= '0;
      else if (tick)
        qcnt <= qcnt + 1'b1;
      if (shutdown || gain_nx > gain)
        strength <= '0;
      else if (tick && strength < RW'(RAMP_STEPS))
        strength <= strength + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      dead  <= '0;
    end else if (!active) begin
      phase <= 1'b0;
      dead  <= '0;
    end else if (tick) begin
      phase <= ~phase;
      dead  <= DW'(DEAD_CLKS);
    end else if (dead != '0) begin
      dead  <= dead - 1'b1;
    end
  end

  assign ph_a = active && !phase && (dead == '0);
  assign ph_b = active &&  phase && (dead == '0);

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ph_a && ph_b)); // R9
  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) gain != 2'd3); // R2
  AST_SD_UNITY: assert property (@(posedge clk) disable iff (!rst_n) shutdown |=> gain == 2'd0); // R7
  AST_FALLBACK_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    (fallback && !shutdown && !force_en) |=> gain == 2'd0); // R5
  AST_RISE_RAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (gain > $past(gain)) |-> strength == '0); // R8
  AST_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (gain == 2'd2 && $past(gain) == 2'd0) |-> $past(force_en)); // R2
  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_b) |-> !$past(ph_a)); // R9

endmodule

// File: tb/pump_gain_ctrl_bench.sv
module pump_gain_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4, QT = 5, RS = 6, DC = 2;
  localparam int RW = $clog2(RS + 1);

  logic clk = 0, rst_n = 0, tick = 0;
  logic [NCH-1:0] drop_in = 0, chan_on = '1, chan_gpo = 0;
  logic commit = 0, grad_down_done = 0, blink_end = 0, sd_bit = 0, force_en = 0;
  logic [1:0] force_sel = 0, gain;
  logic shutdown, ph_a, ph_b;
  logic [RW-1:0] strength;

  int errors = 0, checks = 0;
  int m_gain = 0, m_q = 0, m_s = 0, m_dead = 0;
  bit m_ph = 0;

  pump_gain_ctrl #(.NCH(NCH), .QUAL_TICKS(QT), .RAMP_STEPS(RS), .DEAD_CLKS(DC)) u_pump_gain_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .drop_in(drop_in), .chan_on(chan_on),
    .chan_gpo(chan_gpo), .commit(commit), .grad_down_done(grad_down_done),
    .blink_end(blink_end), .sd_bit(sd_bit), .force_en(force_en), .force_sel(force_sel),
    .gain(gain), .shutdown(shutdown), .strength(strength), .ph_a(ph_a), .ph_b(ph_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_sd();
    return sd_bit || (chan_on == '0);
  endfunction

  function automatic bit exp_active();
    return !exp_sd() && m_gain != 0;
  endfunction

  task automatic cyc();
    bit q, fb, stp, sd;
    int ng;
    sd  = exp_sd();
    q   = |(drop_in & chan_on & ~chan_gpo);
    fb  = commit || grad_down_done || blink_end;
    stp = tick && q && m_gain != 2 && m_q == QT - 1;
    if (sd) ng = 0;
    else if (force_en) ng = (force_sel == 3) ? 2 : int'(force_sel);
    else if (fb) ng = 0;
    else if (stp) ng = m_gain + 1;
    else ng = m_gain;
    if (!exp_active()) begin m_ph = 0; m_dead = 0; end
    else if (tick) begin m_ph = !m_ph; m_dead = DC; end
    else if (m_dead > 0) m_dead--;
    if (sd || force_en || fb || !q || ng != m_gain || m_gain == 2) m_q = 0;
    else if (tick) m_q++;
    if (sd || ng > m_gain) m_s = 0;
    else if (tick && m_s < RS) m_s++;
    m_gain = ng;
    @(posedge clk); #1;
    chk("R2 gain", int'(gain), m_gain);
    chk("R8 strength", int'(strength), m_s);
    chk("R7 shutdown", int'(shutdown), int'(exp_sd()));
    chk("R9 ph_a", int'(ph_a), int'(exp_active() && !m_ph && m_dead == 0));
    chk("R9 ph_b", int'(ph_b), int'(exp_active() && m_ph && m_dead == 0));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 gain", int'(gain), 0);
    chk("R1 strength", int'(strength), 0);
    chk("R1 phases", int'({ph_a, ph_b}), 0);
    tick = 1;
    // R4: ignored channels
    chan_on = 4'b1110; drop_in = 4'b0001; run(15);
    chk("R4 disabled", int'(gain), 0);
    chan_on = '1; chan_gpo = 4'b0010; drop_in = 4'b0010; run(15);
    chk("R4 gpo", int'(gain), 0);
    // R2 and R10: stepping
    chan_gpo = 0; drop_in = 4'b0001; run(QT - 1);
    chk("R2 before hold", int'(gain), 0);
    run(1);
    chk("R2 first step", int'(gain), 1);
    chk("R8 ramp restart", int'(strength), 0);
    run(QT - 1);
    chk("R10 hold restarted", int'(gain), 1);
    run(1);
    chk("R2 second step", int'(gain), 2);
    run(20);
    chk("R2 cap", int'(gain), 2);
    chk("R8 saturate", int'(strength), RS);
    // R5
    blink_end = 1; run(1); blink_end = 0;
    chk("R5 blink fallback", int'(gain), 0);
    // R3
    run(QT - 1); drop_in = 0; run(1); drop_in = 4'b0001; run(QT - 1);
    chk("R3 restart", int'(gain), 0);
    run(1);
    chk("R3 step after restart", int'(gain), 1);
    // R5 collision with step
    grad_down_done = 1; run(1); grad_down_done = 0;
    run(QT - 1); commit = 1; run(1); commit = 0;
    chk("R5 commit beats step", int'(gain), 0);
    // R6
    force_en = 1; force_sel = 2; run(1);
    chk("R6 force 2x", int'(gain), 2);
    force_sel = 0; run(12);
    chk("R6 force 1x holds", int'(gain), 0);
    force_sel = 3; run(1);
    chk("R6 code 3", int'(gain), 2);
    force_sel = 1; run(1);
    chk("R6 force 1.5x", int'(gain), 1);
    force_en = 0;
    // R7
    sd_bit = 1; run(2);
    chk("R7 sd bit", int'(shutdown), 1);
    chk("R7 sd gain", int'(gain), 0);
    sd_bit = 0; chan_on = 0; run(2);
    chk("R7 all off", int'(shutdown), 1);
    chan_on = '1;
    // random
    void'($urandom(32'h5eed1));
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom % 3) == 0;
      drop_in = ($urandom % 8 != 0) ? NCH'($urandom) : '0;
      chan_on = ($urandom % 50 == 0) ? '0 : NCH'($urandom) | NCH'(1);
      chan_gpo = ($urandom % 4 == 0) ? NCH'($urandom) : '0;
      commit = ($urandom % 60) == 0;
      grad_down_done = ($urandom % 90) == 0;
      blink_end = ($urandom % 90) == 0;
      sd_bit = ($urandom % 80) == 0;
      if ($urandom % 100 == 0) force_en = !force_en;
      force_sel = 2'($urandom);
      cyc();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule